// File: doc/BRIEF.md
# Lock Detector Integration Controller

This block sequences a lock-detector accumulator. Every valid sample of an unsigned detection metric is added to a running sum. When the programmed number of samples has been summed, the total is copied into a result register, the accumulator clears, and a new integration cycle may begin.

The controller runs in one of two modes.

- **Free-running mode:** integration cycles follow one another without a pause. A host that wants a stable value writes a halt request. The controller finishes the cycle in progress, freezes, and raises a ready flag.
- **Host-paced mode:** the controller freezes by itself after every cycle.

In both modes, a restart write releases the frozen controller, and that restart starts the next cycle.

The host uses a simple write port: an enable, an address and a data word. Only the address selects the action. The result and a status word are registered outputs.

Top module: `lockdet_integ_ctrl`

## Requirements
- R1: A halt write in free-running mode never stops a cycle early. The controller keeps summing until the cycle's final sample. A halt write that arrives in the same clock as that final sample also takes effect at the end of that cycle.
- R2: While stopped, the controller ignores metric samples, and `result_o` keeps its value until a restart write is accepted.
- R3: Bit 7 of `status_o` is 1 exactly while the controller is stopped with a frozen result. All other status bits are 0.
- R4: In host-paced mode (`host_mode_i`=1) the controller stops after every cycle, with no halt write needed.
- R5: A restart write to a stopped controller starts a new cycle. The accumulator is cleared, the sample count is zeroed and the cycle length is loaded.
- R6: A halt is a write to address 24 and a restart is a write to address 25. Writes to any other address have no effect, and the write data is never used.
- R7: After a cycle, `result_o` equals the sum of exactly N valid samples taken in that cycle. N is `cycle_len_i` as loaded at the start of the cycle, and a value of 0 counts as 1. Clocks with `metric_vld_i`=0 are not counted.
- R8: In free-running mode, with no halt requested, the next cycle starts immediately after the previous one. `result_o` is updated at the end of every cycle, and the status bit stays 0.
- R9: The following writes are ignored:
  - a restart while the controller is running, which leaves the current sum and count untouched;
  - a halt while already stopped;
  - a halt written in host-paced mode, which is not remembered later.
- R10: The status bit clears on the clock edge that accepts a restart.
- R11: Synchronous reset puts the controller into a running state. The sum and count are cleared, the length is loaded from `cycle_len_i`, `result_o` is 0 and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| metric_i | input | METRIC_W | Unsigned per-sample detection metric |
| metric_vld_i | input | 1 | Metric sample valid |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_data_i | input | DATA_W | Host write data (unused) |
| host_mode_i | input | 1 | 1 = host-paced mode, 0 = free-running mode |
| cycle_len_i | input | LEN_W | Samples per integration cycle (0 counts as 1) |
| status_o | output | 8 | Status word; bit 7 = result frozen and readable |
| result_o | output | METRIC_W+LEN_W | Latched sum of the last completed cycle |

## Verification
Errors in the internal state show up at the ports in different ways:
- **Wrong sample count:** a wrong value in `result_o` at the very first cycle end.
- **Lost or premature stop state:** the ready bit rises one sample early or late, or `result_o` changes while the controller should be frozen, within one sample of the fault.
- **Stale halt request:** a stop one whole cycle later than expected.

The bench sweeps every cycle length of a narrow configuration in host-paced mode and checks the sum and the ready edge around each final sample. It then exercises each ignored-write case and reads the effect back through the status and result outputs before the next command.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  localparam int STATUS_W  = 8;
  localparam int READY_BIT = 7;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_STOP = 1'b1
  } lockdet_state_e;
endpackage

// File: rtl/lockdet_wr_decode.sv
module lockdet_wr_decode #(
  parameter int ADDR_W       = 5,
  parameter int HALT_ADDR    = 24,
  parameter int RESTART_ADDR = 25
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              halt_req_o,
  output logic              restart_req_o
);
  localparam logic [ADDR_W-1:0] HALT_A    = ADDR_W'(HALT_ADDR);
  localparam logic [ADDR_W-1:0] RESTART_A = ADDR_W'(RESTART_ADDR);

  always_comb begin
    halt_req_o    = wr_en_i && (wr_addr_i == HALT_A);
    restart_req_o = wr_en_i && (wr_addr_i == RESTART_A);
  end
endmodule

// File: rtl/lockdet_seq.sv
module lockdet_seq
  import lockdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic host_mode_i,
  input  logic halt_req_i,
  input  logic restart_req_i,
  input  logic cyc_end_i,
  output logic running_o,
  output logic start_o,
  output logic ready_o,
  output logic halt_pend_o
);
  lockdet_state_e state_q;
  logic           pend_q;
  logic           ready_q;
  logic           halt_take;
  logic           stop_now;

  // A halt only counts while running in free-running mode.
  always_comb begin
    halt_take = halt_req_i && !host_mode_i && (state_q == ST_RUN);
    stop_now  = cyc_end_i && (host_mode_i || pend_q || halt_take);
    start_o   = (state_q == ST_STOP) && restart_req_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      pend_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (stop_now) begin
            state_q <= ST_STOP;
            ready_q <= 1'b1;
            pend_q  <= 1'b0;
          end else if (halt_take) begin
            pend_q <= 1'b1;
          end
        end
        ST_STOP: begin
          if (start_o) begin
            state_q <= ST_RUN;
            ready_q <= 1'b0;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign running_o   = (state_q == ST_RUN);
  assign ready_o     = ready_q;
  assign halt_pend_o = pend_q;
endmodule

// File: rtl/lockdet_accum.sv
module lockdet_accum #(
  parameter int METRIC_W = 12,
  parameter int LEN_W    = 16,
  localparam int ACC_W   = METRIC_W + LEN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_i,
  input  logic                start_i,
  input  logic [METRIC_W-1:0] metric_i,
  input  logic                metric_vld_i,
  input  logic [LEN_W-1:0]    cycle_len_i,
  output logic                cyc_end_o,
  output logic [ACC_W-1:0]    result_o
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] last_idx;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] res_q;
  logic [ACC_W-1:0] sum_next;
  logic             take;

  always_comb begin
    last_idx  = (len_q == '0) ? '0 : len_q - 1'b1;
    take      = run_i && metric_vld_i;
    cyc_end_o = take && (cnt_q == last_idx);
    sum_next  = acc_q + ACC_W'(metric_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      acc_q <= '0;
      res_q <= '0;
      len_q <= cycle_len_i;
    end else if (start_i) begin
      cnt_q <= '0;
      acc_q <= '0;
      len_q <= cycle_len_i;
    end else if (take) begin
      if (cnt_q == last_idx) begin
        res_q <= sum_next;
        acc_q <= '0;
        cnt_q <= '0;
        len_q <= cycle_len_i;
      end else begin
        acc_q <= sum_next;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/lockdet_integ_ctrl.sv
module lockdet_integ_ctrl
  import lockdet_pkg::*;
#(
  parameter int METRIC_W     = 12,
  parameter int LEN_W        = 16,
  parameter int ADDR_W       = 5,
  parameter int DATA_W       = 32,
  parameter int HALT_ADDR    = 24,
  parameter int RESTART_ADDR = 25
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [METRIC_W-1:0]       metric_i,
  input  logic                      metric_vld_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  input  logic                      host_mode_i,
  input  logic [LEN_W-1:0]          cycle_len_i,
  output logic [STATUS_W-1:0]       status_o,
  output logic [METRIC_W+LEN_W-1:0] result_o
);
  logic halt_req;
  logic restart_req;
  logic running;
  logic start;
  logic ready;
  logic halt_pend;
  logic cyc_end;
  logic data_unused;

  assign data_unused = ^wr_data_i;

  lockdet_wr_decode #(
    .ADDR_W      (ADDR_W),
    .HALT_ADDR   (HALT_ADDR),
    .RESTART_ADDR(RESTART_ADDR)
  ) dec_i (
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .halt_req_o   (halt_req),
    .restart_req_o(restart_req)
  );

  lockdet_seq seq_i (
    .clk          (clk),
    .rst          (rst),
    .host_mode_i  (host_mode_i),
    .halt_req_i   (halt_req),
    .restart_req_i(restart_req),
    .cyc_end_i    (cyc_end),
    .running_o    (running),
    .start_o      (start),
    .ready_o      (ready),
    .halt_pend_o  (halt_pend)
  );

  lockdet_accum #(
    .METRIC_W(METRIC_W),
    .LEN_W   (LEN_W)
  ) acc_i (
    .clk         (clk),
    .rst         (rst),
    .run_i       (running),
    .start_i     (start),
    .metric_i    (metric_i),
    .metric_vld_i(metric_vld_i),
    .cycle_len_i (cycle_len_i),
    .cyc_end_o   (cyc_end),
    .result_o    (result_o)
  );

  for (genvar b = 0; b < STATUS_W; b++) begin : g_status
    if (b == READY_BIT) begin : g_ready
      assign status_o[b] = ready;
    end else begin : g_zero
      assign status_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/lockdet_integ_ctrl_chk.sv
module lockdet_integ_ctrl_chk #(
  parameter int RES_W        = 28,
  parameter int ADDR_W       = 5,
  parameter int RESTART_ADDR = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              running,
  input logic              cyc_end,
  input logic              host_mode,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        status,
  input logic [RES_W-1:0]  result
);
  logic restart_wr;
  assign restart_wr = wr_en && (wr_addr == ADDR_W'(RESTART_ADDR));

  AST_STOP_AT_CYCLE_END: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(cyc_end)); // R1
  AST_HOLD_UNTIL_RESTART: assert property (@(posedge clk) disable iff (rst)
    (!running && !restart_wr) |=> !running); // R2
  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !running |=> $stable(result)); // R2
  AST_READY_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    status[7] == !running); // R3
  AST_HOST_AUTOSTOP: assert property (@(posedge clk) disable iff (rst)
    (host_mode && cyc_end) |=> (!running && status[7])); // R4
  AST_RESTART_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    (!running && restart_wr) |=> (running && !status[7])); // R10
endmodule

bind lockdet_integ_ctrl lockdet_integ_ctrl_chk #(
  .RES_W       (METRIC_W + LEN_W),
  .ADDR_W      (ADDR_W),
  .RESTART_ADDR(RESTART_ADDR)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .running  (running),
  .cyc_end  (cyc_end),
  .host_mode(host_mode_i),
  .wr_en    (wr_en_i),
  .wr_addr  (wr_addr_i),
  .status   (status_o),
  .result   (result_o)
);

// File: tb/lockdet_integ_ctrl_tb_top.sv
`timescale 1ns/1ps
module lockdet_integ_ctrl_tb_top;
  localparam int MW = 4;
  localparam int LW = 4;
  localparam int RW = MW + LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [MW-1:0] metric_i = '0;
  logic          metric_vld_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [4:0]    wr_addr_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic          host_mode_i = 1'b1;
  logic [LW-1:0] cycle_len_i = '0;
  logic [7:0]    status_o;
  logic [RW-1:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lockdet_integ_ctrl #(.METRIC_W(MW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst(rst), .metric_i(metric_i), .metric_vld_i(metric_vld_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .host_mode_i(host_mode_i), .cycle_len_i(cycle_len_i),
    .status_o(status_o), .result_o(result_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int m);
    metric_i = MW'(m);
    metric_vld_i = 1'b1;
    @(negedge clk);
    metric_vld_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en_i = 1'b1;
    wr_addr_i = 5'(a);
    wr_data_i = 32'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sum;
    int s1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    chk("R11 status", int'(status_o), 0);
    chk("R11 result", int'(result_o), 0);

    // Host-paced sweep over every cycle length (length 0 latched at reset)
    for (int len = 0; len < 16; len++) begin
      int n;
      n = (len == 0) ? 1 : len;
      cycle_len_i = LW'(len);
      if (len != 0) begin
        wr(25, len * 1234567);
        chk("R10 status cleared by restart", int'(status_o), 0);
      end
      sum = 0;
      for (int k = 0; k < n; k++) begin
        int m;
        m = (k * 5 + len * 3 + 1) % 16;
        if (k == n - 1) chk("R4 not stopped before last sample", int'(status_o), 0);
        if (k % 2 == 1) idle();
        push(m);
        sum += m;
      end
      chk("R4 auto-stop status", int'(status_o), 8'h80);
      chk("R7 result sum", int'(result_o), sum);
      chk("R5 R3 ready only bit 7", int'(status_o & 8'h7F), 0);
      push(9); push(7);
      chk("R2 result held while stopped", int'(result_o), sum);
      wr(23, 0); wr(26, 0);
      chk("R6 other addresses no effect", int'(status_o), 8'h80);
      push(3);
      chk("R6 still frozen", int'(result_o), sum);
    end

    // Free-running continuous cycles
    host_mode_i = 1'b0;
    cycle_len_i = 3;
    wr(25, 0);
    push(1); push(2); push(4);
    chk("R8 cycle A result", int'(result_o), 7);
    chk("R8 cycle A keeps running", int'(status_o), 0);
    push(5); idle(); push(6); push(7);
    chk("R8 cycle B result", int'(result_o), 18);
    chk("R8 cycle B keeps running", int'(status_o), 0);

    // Restart while running is ignored
    push(2); wr(25, 0); push(3); push(4);
    chk("R9 restart while running ignored", int'(result_o), 9);

    // Halt mid-cycle
    push(8); wr(24, 0);
    chk("R1 no stop after halt write", int'(status_o), 0);
    push(1);
    chk("R1 still running mid-cycle", int'(status_o), 0);
    chk("R1 result not updated mid-cycle", int'(result_o), 9);
    push(6);
    chk("R1 stop at cycle end", int'(status_o), 8'h80);
    chk("R1 halted result", int'(result_o), 15);
    push(5);
    chk("R2 samples ignored when halted", int'(result_o), 15);
    wr(24, 0);
    wr(25, 99);
    chk("R10 restart clears status", int'(status_o), 0);
    push(1); push(1); push(1);
    chk("R9 halt while halted ignored", int'(status_o), 0);
    chk("R9 cycle after restart", int'(result_o), 3);

    // Halt written together with the final sample
    push(2); push(2);
    metric_i = 4'd9; metric_vld_i = 1'b1;
    wr_en_i = 1'b1; wr_addr_i = 5'd24;
    @(negedge clk);
    metric_vld_i = 1'b0; wr_en_i = 1'b0;
    chk("R1 halt with final sample", int'(status_o), 8'h80);
    chk("R1 halt with final sample result", int'(result_o), 13);

    // Halt in host-paced mode is not remembered
    host_mode_i = 1'b1;
    wr(25, 0);
    push(3); wr(24, 0);
    host_mode_i = 1'b0;
    push(3); push(3);
    chk("R9 host-mode halt forgotten", int'(status_o), 0);
    chk("R7 result after mode switch", int'(result_o), 9);
    s1 = 0;
    for (int k = 0; k < 3; k++) begin
      push(k + 10);
      s1 += k + 10;
    end
    chk("R8 next cycle runs", int'(status_o), 0);
    chk("R8 next cycle sum", int'(result_o), s1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule